// File: doc/BRIEF.md
# Latched Fault Protection Supervisor

This block guards the switching stage of an offline LED driver. It watches the digital outputs of comparators for output overvoltage and primary overcurrent, plus an over-temperature flag. Each detector is trusted only in its own gate phase and only once a blanking delay has run out after that phase began. The first fault turns switching off at once and records a fault code. Switching stays off, and the code stays unchanged, until the supply falls below its turn-off level and then climbs back above its turn-on level.

The supply comparators give a hysteretic start and stop. Switching is enabled when the above-turn-on comparator fires while the block is idle. It is disabled when the below-turn-off comparator fires. The overvoltage blanking has two lengths, and the multiplier-low flag picks which one applies. The analog references, the comparators themselves and the supply charging path belong to the surrounding design.

Top module: `fault_latch_supervisor`

## Requirements
- R1: During and after reset, `sw_enable` is 0 and `fault_code` is 0 (code values: 0 none, 1 overvoltage, 2 overcurrent, 3 over-temperature).
- R2: While idle, an asserted `vcc_above_on` (with `vcc_below_off` low) raises `sw_enable` one clock later. Without it, the block stays disabled.
- R3: While running, an asserted `vcc_below_off` drops `sw_enable` one clock later and leaves `fault_code` at 0.
- R4: With `mult_low` = 0, `ovp_cmp` latches code 1 only while `gate_on` = 0 and only when it is seen at least `OVP_BLANK_LONG` cycles after the gate turned off. The first sampled cycle of a gate phase is cycle 0.
- R5: With `mult_low` = 1, the overvoltage blanking is `OVP_BLANK_SHORT` cycles instead.
- R6: `ocp_cmp` latches code 2 only while `gate_on` = 1 and only when it is seen at least `OCP_BLANK` cycles after the gate turned on.
- R7: `ovp_cmp` has no effect while the gate is on, and `ocp_cmp` has no effect while the gate is off.
- R8: A comparator pulse that lies entirely inside its blanking window latches nothing.
- R9: `hot_flag` while running latches code 3 with no blanking, and `sw_enable` drops one clock later.
- R10: Once latched, `sw_enable` stays 0 and `fault_code` keeps the first fault's value, whatever later faults or `vcc_above_on` do.
- R11: `vcc_below_off` in the latched state clears `fault_code` to 0 one clock later. After that, switching resumes only after `vcc_above_on` is asserted.
- R12: When several faults are accepted in the same cycle, over-temperature (3) wins over overcurrent (2), which wins over overvoltage (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ovp_cmp | input | 1 | Overvoltage comparator on the zero-crossing sense node |
| ocp_cmp | input | 1 | Overcurrent comparator on the current-sense node |
| hot_flag | input | 1 | Die over-temperature flag |
| vcc_above_on | input | 1 | Supply above turn-on threshold |
| vcc_below_off | input | 1 | Supply below turn-off threshold |
| gate_on | input | 1 | Present power-switch gate state |
| mult_low | input | 1 | Multiplier output at or below its low level |
| sw_enable | output | 1 | Switching permitted |
| fault_code | output | 2 | First latched fault (0 none, 1 OVP, 2 OCP, 3 OTP) |

## Verification
The hardest case to reach is a comparator edge that falls exactly on the last blanked cycle or the first accepted cycle of a gate phase, in each of the three blanking variants. A vector table handles this. Before each vector, the block passes through an undervoltage cycle, and the gate is held in the opposite phase. The bench then toggles the gate and places a comparator pulse at a chosen cycle offset from that toggle, with a chosen length. This puts single pulses one cycle before and exactly at each blanking limit, and long pulses in the wrong gate phase. Directed tests then pile later faults and turn-on events onto a latched state to show that the code is sticky and that the release order is enforced.

// File: rtl/fault_latch_supervisor.sv
module fault_latch_supervisor #(
  parameter int OVP_BLANK_LONG  = 200,
  parameter int OVP_BLANK_SHORT = 100,
  parameter int OCP_BLANK       = 35
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovp_cmp,
  input  logic       ocp_cmp,
  input  logic       hot_flag,
  input  logic       vcc_above_on,
  input  logic       vcc_below_off,
  input  logic       gate_on,
  input  logic       mult_low,
  output logic       sw_enable,
  output logic [1:0] fault_code
);

  localparam int MAXB_A = (OVP_BLANK_LONG > OVP_BLANK_SHORT) ? OVP_BLANK_LONG : OVP_BLANK_SHORT;
  localparam int MAXB   = (MAXB_A > OCP_BLANK) ? MAXB_A : OCP_BLANK;
  localparam int AW     = $clog2(MAXB + 1) + 1;
  localparam logic [AW-1:0] AGE_SAT = '1;
  localparam logic [AW-1:0] OVL = AW'(OVP_BLANK_LONG);
  localparam logic [AW-1:0] OVS = AW'(OVP_BLANK_SHORT);
  localparam logic [AW-1:0] OCB = AW'(OCP_BLANK);

  localparam logic [1:0] CODE_NONE = 2'd0;
  localparam logic [1:0] CODE_OVP  = 2'd1;
  localparam logic [1:0] CODE_OCP  = 2'd2;
  localparam logic [1:0] CODE_OTP  = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_LATCH} st_t;

  st_t           state;
  logic          gate_q;
  logic [AW-1:0] age_q;
  logic [AW-1:0] age_now;
  logic          ovp_hit;
  logic          ocp_hit;
  logic [1:0]    trip_code;

  assign age_now = (gate_on != gate_q) ? '0 : age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      age_q  <= '0;
    end else begin
      gate_q <= gate_on;
      age_q  <= (age_now == AGE_SAT) ? age_now : age_now + 1'b1;
    end
  end

  assign ovp_hit = !gate_on && ovp_cmp && (age_now >= (mult_low ? OVS : OVL));
  assign ocp_hit =  gate_on && ocp_cmp && (age_now >= OCB);

  assign trip_code = hot_flag ? CODE_OTP :
                     ocp_hit  ? CODE_OCP :
                     ovp_hit  ? CODE_OVP : CODE_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      fault_code <= CODE_NONE;
    end else begin
      case (state)
        ST_IDLE:
          if (vcc_above_on && !vcc_below_off) state <= ST_RUN;
        ST_RUN:
          if (vcc_below_off) state <= ST_IDLE;
          else if (trip_code != CODE_NONE) begin
            state      <= ST_LATCH;
            fault_code <= trip_code;
          end
        ST_LATCH:
          if (vcc_below_off) begin
            state      <= ST_IDLE;
            fault_code <= CODE_NONE;
          end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sw_enable = (state == ST_RUN);

  // R2
  start_needs_turn_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_enable) |-> $past(vcc_above_on));

  // R10
  code_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code != CODE_NONE && !vcc_below_off) |=> $stable(fault_code) && !sw_enable);

  // R6
  ocp_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == CODE_NONE) |=>
      (fault_code != CODE_OCP || ($past(gate_on) && $past(ocp_cmp))));

  // R4
  ovp_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_code == CODE_NONE) |=>
      (fault_code != CODE_OVP || (!$past(gate_on) && $past(ovp_cmp))));

  // R3
  uvlo_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_below_off |=> !sw_enable);

endmodule

// File: tb/fault_latch_supervisor_test.sv
`timescale 1ns/1ps
module fault_latch_supervisor_test;

  localparam int OVL = 20;
  localparam int OVS = 10;
  localparam int OCB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovp_cmp = 0, ocp_cmp = 0, hot_flag = 0;
  logic vcc_above_on = 0, vcc_below_off = 0, gate_on = 0, mult_low = 0;
  logic sw_enable;
  logic [1:0] fault_code;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fault_latch_supervisor #(
    .OVP_BLANK_LONG(OVL), .OVP_BLANK_SHORT(OVS), .OCP_BLANK(OCB)
  ) uut (
    .clk(clk), .rst_n(rst_n), .ovp_cmp(ovp_cmp), .ocp_cmp(ocp_cmp),
    .hot_flag(hot_flag), .vcc_above_on(vcc_above_on), .vcc_below_off(vcc_below_off),
    .gate_on(gate_on), .mult_low(mult_low), .sw_enable(sw_enable), .fault_code(fault_code)
  );

  typedef struct packed {
    logic       gate;
    logic       mlow;
    logic       use_ocp;
    logic [7:0] start;
    logic [7:0] len;
    logic [1:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 8'd0,  8'd20, 2'd0, 8'd8},  // R8 ovp inside long blank
    '{1'b0, 1'b0, 1'b0, 8'd20, 8'd1,  2'd1, 8'd4},  // R4 first accepted cycle
    '{1'b0, 1'b0, 1'b0, 8'd19, 8'd1,  2'd0, 8'd4},  // R4 last blanked cycle
    '{1'b0, 1'b1, 1'b0, 8'd10, 8'd1,  2'd1, 8'd5},  // R5 short blank accepted
    '{1'b0, 1'b1, 1'b0, 8'd9,  8'd1,  2'd0, 8'd5},  // R5 short blank edge
    '{1'b1, 1'b0, 1'b1, 8'd4,  8'd1,  2'd2, 8'd6},  // R6 ocp accepted
    '{1'b1, 1'b0, 1'b1, 8'd0,  8'd4,  2'd0, 8'd8},  // R8 ocp inside blank
    '{1'b1, 1'b0, 1'b0, 8'd0,  8'd30, 2'd0, 8'd7},  // R7 ovp during gate on
    '{1'b0, 1'b0, 1'b1, 8'd0,  8'd30, 2'd0, 8'd7},  // R7 ocp during gate off
    '{1'b1, 1'b1, 1'b1, 8'd25, 8'd3,  2'd2, 8'd6}   // R6 late ocp pulse
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic restart(input logic pre_gate);
    ovp_cmp = 0; ocp_cmp = 0; hot_flag = 0;
    gate_on = pre_gate;
    vcc_below_off = 1;
    @(negedge clk);
    vcc_below_off = 0;
    vcc_above_on = 1;
    @(negedge clk);
    vcc_above_on = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sw_enable == 0, "R1", sw_enable, 0);
    check(fault_code == 0, "R1", fault_code, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R2 stays idle without turn-on
    check(sw_enable == 0, "R2", sw_enable, 0);
    vcc_above_on = 1;
    @(negedge clk);
    vcc_above_on = 0;
    check(sw_enable == 1, "R2", sw_enable, 1);

    // R3 undervoltage stop, no fault code
    vcc_below_off = 1;
    @(negedge clk);
    vcc_below_off = 0;
    check(sw_enable == 0, "R3", sw_enable, 0);
    check(fault_code == 0, "R3", fault_code, 0);

    for (int v = 0; v < NV; v++) begin
      restart(!VECS[v].gate);
      check(sw_enable == 1, "R2", sw_enable, 1);
      gate_on = VECS[v].gate;
      mult_low = VECS[v].mlow;
      for (int k = 0; k < 40; k++) begin
        logic p;
        p = (k >= int'(VECS[v].start)) && (k < int'(VECS[v].start) + int'(VECS[v].len));
        if (VECS[v].use_ocp) ocp_cmp = p; else ovp_cmp = p;
        @(negedge clk);
      end
      ovp_cmp = 0; ocp_cmp = 0;
      check(fault_code == VECS[v].exp, $sformatf("R%0d vec %0d", VECS[v].req, v),
            fault_code, VECS[v].exp);
      check(sw_enable == (VECS[v].exp == 0), $sformatf("R%0d vec %0d en", VECS[v].req, v),
            sw_enable, VECS[v].exp == 0);
    end

    // R9 over-temperature, no blanking
    restart(1'b0);
    gate_on = 1;
    hot_flag = 1;
    @(negedge clk);
    hot_flag = 0;
    check(fault_code == 3, "R9", fault_code, 3);
    check(sw_enable == 0, "R9", sw_enable, 0);

    // R10 sticky first fault: latch OVP, then pile on other events
    restart(1'b1);
    gate_on = 0; mult_low = 1;
    repeat (OVS + 2) @(negedge clk);
    ovp_cmp = 1;
    @(negedge clk);
    ovp_cmp = 0;
    check(fault_code == 1, "R10", fault_code, 1);
    gate_on = 1;
    repeat (OCB + 3) @(negedge clk);
    ocp_cmp = 1; hot_flag = 1; vcc_above_on = 1;
    repeat (5) @(negedge clk);
    ocp_cmp = 0; hot_flag = 0; vcc_above_on = 0;
    check(fault_code == 1, "R10", fault_code, 1);
    check(sw_enable == 0, "R10", sw_enable, 0);

    // R11 release only via undervoltage, then turn-on needed
    vcc_below_off = 1;
    @(negedge clk);
    vcc_below_off = 0;
    check(fault_code == 0, "R11", fault_code, 0);
    repeat (4) @(negedge clk);
    check(sw_enable == 0, "R11", sw_enable, 0);
    vcc_above_on = 1;
    @(negedge clk);
    vcc_above_on = 0;
    check(sw_enable == 1, "R11", sw_enable, 1);

    // R12 simultaneous overcurrent and over-temperature
    gate_on = 0;
    @(negedge clk);
    gate_on = 1;
    repeat (OCB + 2) @(negedge clk);
    ocp_cmp = 1; hot_flag = 1;
    @(negedge clk);
    ocp_cmp = 0; hot_flag = 0;
    check(fault_code == 3, "R12", fault_code, 3);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule